// File: doc/BRIEF.md
# Cache Event Counter Group

This block holds four event counters that observe a two-bank cache. Each counter has its own event-select register holding an 8-bit code. A single run control governs all four: they start together, halt together and are zeroed together. The cache pipeline supplies one pulse line per countable event on `cache_evt`. Software programs the four codes, starts the group, lets it run for a while, halts it, and then reads stable totals.

Control is a two-state machine, HALTED and COUNTING, and it leaves reset in HALTED. The transition START (a write of 1 to the run register) moves HALTED to COUNTING. It also zeroes every count on the same clock edge. START taken while already COUNTING stays in COUNTING and zeroes the counts again. The transition STOP (a write of 0 to the run register) returns to HALTED. The transition REPROGRAM (a write to any select register) also returns to HALTED. A count register is a plain combinational read, so a read while counting returns the value held in that cycle.

Top module: `cevg_top`

## Requirements
- R1: After reset, every count register and every select register reads 0, and the run register reads 0.
- R2: Read address 0x0 to 0x3 returns counts 0 to 3. Read address 0x4 to 0x7 returns select codes 0 to 3. Read address 0x8 returns the run state in bit 0. Every other read address returns 0. Reads are combinational and reflect the current cycle.
- R3: A write of 0x01 to address 0x8 zeroes all four counts on that clock edge and enters COUNTING. Counting starts from the next cycle, and the run register then reads 1. This also holds when the group is already counting.
- R4: A write of 0x00 to address 0x8 halts the group, and the run register reads 0. A write to 0x8 of any value other than 0x00 or 0x01 changes nothing.
- R5: A write to address 0x4+i stores the code in select register i and halts the whole group. The run register reads 0 afterwards, and every count keeps its value.
- R6: While counting, code 0x01 adds one to its count every cycle. Code 0x00, and every code of 0x2C or above, never adds to its count.
- R7: While counting, code c in the range 0x02 to 0x2B adds one in each cycle where `cache_evt[c-2]` is high. Examples: bank 0/1 hits are 0x17/0x18 (bits 21/22), misses 0x19/0x1A (bits 23/24), and evictions 0x1D/0x1E (bits 27/28).
- R8: While halted, no count changes, whatever `cache_evt` does.
- R9: Writes to addresses 0x0 to 0x3 and to unmapped addresses have no effect on any register.
- R10: Each count is COUNT_W bits wide and wraps to zero past its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Write address |
| cfg_wdata | input | 8 | Write data |
| cfg_rd_addr | input | 4 | Read address |
| cfg_rdata | output | max(COUNT_W,8) | Read data for `cfg_rd_addr`, combinational |
| cache_evt | input | EVT_N | Event pulses; bit k belongs to code k+2 |

## Verification
Assertions check on every cycle the properties of the state machine and the counters: REPROGRAM and STOP always land in HALTED, and START always lands in COUNTING with all counts zero. They also check that a halted count never moves and that codes 0x01 and 0x00 add exactly one and exactly nothing. Only the bench scenarios can show the following: that the right event bit is routed to each code, and that unmapped and out-of-range accesses are harmless. The scenarios also show that a live read reflects the current cycle and that a narrow counter really wraps. These are compared against a cycle-accurate model in the bench, under directed sequences and a long seeded random run.

// File: rtl/cevg_pkg.sv
package cevg_pkg;

    localparam int CODE_W = 8;
    localparam int ADDR_W = 4;
    localparam int LANES  = 4;

    localparam logic [CODE_W-1:0] CODE_OFF  = 8'h00;
    localparam logic [CODE_W-1:0] CODE_TICK = 8'h01;
    localparam int                CODE_BASE = 2;

    localparam logic [CODE_W-1:0] RUN_START = 8'h01;
    localparam logic [CODE_W-1:0] RUN_STOP  = 8'h00;

    localparam logic [ADDR_W-1:0] ADDR_RUN  = 4'h8;
    localparam logic [1:0]        PAGE_CNT  = 2'b00;
    localparam logic [1:0]        PAGE_SEL  = 2'b01;

    typedef enum logic {
        GRP_HALTED   = 1'b0,
        GRP_COUNTING = 1'b1
    } grp_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic reprog;
    } grp_cmd_t;

endpackage

// File: rtl/cevg_ctrl.sv
module cevg_ctrl
    import cevg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  grp_cmd_t cmd,
    output logic     running,
    output logic     clr_all,
    output logic     cnt_step
);

    grp_state_e state_q;
    grp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRP_HALTED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRP_HALTED: begin
                if (cmd.start) begin
                    state_d = GRP_COUNTING;
                end
            end
            GRP_COUNTING: begin
                if (cmd.stop || cmd.reprog) begin
                    state_d = GRP_HALTED;
                end
            end
            default: state_d = GRP_HALTED;
        endcase
    end

    always_comb begin
        running  = (state_q == GRP_COUNTING);
        clr_all  = cmd.start;
        cnt_step = running && !(cmd.start || cmd.stop || cmd.reprog);
    end

    // R5
    reprog_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.reprog |=> !running);

    // R4
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.stop |=> !running);

    // R3
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.start |=> running);

endmodule

// File: rtl/cevg_evt_mux.sv
module cevg_evt_mux
    import cevg_pkg::*;
#(
    parameter int EVT_N = 42
)(
    input  logic [CODE_W-1:0] code,
    input  logic [EVT_N-1:0]  evts,
    output logic              hit
);

    always_comb begin
        hit = 1'b0;
        if (code == CODE_TICK) begin
            hit = 1'b1;
        end
        for (int k = 0; k < EVT_N; k++) begin
            if (code == CODE_W'(k + CODE_BASE)) begin
                hit = evts[k];
            end
        end
    end

endmodule

// File: rtl/cevg_lane.sv
module cevg_lane
    import cevg_pkg::*;
#(
    parameter int COUNT_W = 48,
    parameter int EVT_N   = 42
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [CODE_W-1:0]  sel_wdata,
    input  logic               clr_all,
    input  logic               cnt_step,
    input  logic [EVT_N-1:0]   cache_evt,
    output logic [CODE_W-1:0]  sel_q,
    output logic [COUNT_W-1:0] cnt_q
);

    logic hit;

    cevg_evt_mux #(.EVT_N(EVT_N)) u_mux (
        .code (sel_q),
        .evts (cache_evt),
        .hit  (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= CODE_OFF;
        end else if (sel_wr) begin
            sel_q <= sel_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_all) begin
            cnt_q <= '0;
        end else if (cnt_step && hit) begin
            cnt_q <= cnt_q + COUNT_W'(1);
        end
    end

    // R8
    halted_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_step && !clr_all) |=> $stable(cnt_q));

    // R3
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (cnt_q == '0));

    // R6
    tick_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && sel_q == CODE_TICK) |=> (cnt_q == $past(cnt_q) + COUNT_W'(1)));

    // R6
    off_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && sel_q == CODE_OFF) |=> $stable(cnt_q));

endmodule

// File: rtl/cevg_top.sv
module cevg_top
    import cevg_pkg::*;
#(
    parameter int COUNT_W = 48,
    parameter int EVT_N   = 42
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CODE_W-1:0]     cfg_wdata,
    input  logic [ADDR_W-1:0]     cfg_rd_addr,
    output logic [((COUNT_W > CODE_W) ? COUNT_W : CODE_W)-1:0] cfg_rdata,
    input  logic [EVT_N-1:0]      cache_evt
);

    localparam int RD_W  = (COUNT_W > CODE_W) ? COUNT_W : CODE_W;
    localparam int IDX_W = $clog2(LANES);

    grp_cmd_t           cmd;
    logic               running;
    logic               clr_all;
    logic               cnt_step;
    logic [LANES-1:0]   sel_wr;
    logic [CODE_W-1:0]  sel_arr [LANES];
    logic [COUNT_W-1:0] cnt_arr [LANES];

    always_comb begin
        cmd.reprog = cfg_wr && (cfg_addr[ADDR_W-1:IDX_W] == PAGE_SEL);
        cmd.start  = cfg_wr && (cfg_addr == ADDR_RUN) && (cfg_wdata == RUN_START);
        cmd.stop   = cfg_wr && (cfg_addr == ADDR_RUN) && (cfg_wdata == RUN_STOP);
    end

    cevg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .running  (running),
        .clr_all  (clr_all),
        .cnt_step (cnt_step)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sel_wr[i] = cmd.reprog && (cfg_addr[IDX_W-1:0] == IDX_W'(i));

        cevg_lane #(
            .COUNT_W (COUNT_W),
            .EVT_N   (EVT_N)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_wr    (sel_wr[i]),
            .sel_wdata (cfg_wdata),
            .clr_all   (clr_all),
            .cnt_step  (cnt_step),
            .cache_evt (cache_evt),
            .sel_q     (sel_arr[i]),
            .cnt_q     (cnt_arr[i])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd_addr[ADDR_W-1:IDX_W] == PAGE_CNT) begin
            cfg_rdata = RD_W'(cnt_arr[cfg_rd_addr[IDX_W-1:0]]);
        end else if (cfg_rd_addr[ADDR_W-1:IDX_W] == PAGE_SEL) begin
            cfg_rdata = RD_W'(sel_arr[cfg_rd_addr[IDX_W-1:0]]);
        end else if (cfg_rd_addr == ADDR_RUN) begin
            cfg_rdata = RD_W'(running);
        end
    end

    // R5
    reprog_keeps_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.reprog |=> (cnt_arr[0] == $past(cnt_arr[0])));

endmodule

// File: tb/tb_cevg_top.sv
module tb_cevg_top;
    import cevg_pkg::*;

    localparam int CW  = 48;
    localparam int CWN = 8;
    localparam int EN  = 42;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [3:0]    cfg_rd_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [EN-1:0] cache_evt = '0;
    logic [CW-1:0] rdata;
    logic [7:0]    rdata_w;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic [CW-1:0] m_cnt [4];
    logic [7:0]    m_sel [4];
    logic          m_run;

    always #10 clk = ~clk;

    cevg_top #(.COUNT_W(CW), .EVT_N(EN)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(rdata),
        .cache_evt(cache_evt)
    );

    cevg_top #(.COUNT_W(CWN), .EVT_N(EN)) dut_w (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(rdata_w),
        .cache_evt(cache_evt)
    );

    function automatic logic evt_hit(logic [7:0] code, logic [EN-1:0] e);
        if (code == 8'h01) return 1'b1;
        if (code >= 8'h02 && code < 8'(EN + 2)) return e[code - 8'h02];
        return 1'b0;
    endfunction

    function automatic logic [CW-1:0] model_read(logic [3:0] a);
        if (a < 4) return m_cnt[a[1:0]];
        if (a < 8) return CW'(m_sel[a[1:0]]);
        if (a == 4'h8) return CW'(m_run);
        return '0;
    endfunction

    function automatic string tag_of(logic [3:0] a);
        if (a < 4) return "R7";
        if (a < 8) return "R5";
        if (a == 4'h8) return "R4";
        return "R2";
    endfunction

    task automatic compare(string tag, logic [3:0] a, logic [CW-1:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0h wide got %0h expected %0h", tag, a, rdata, exp);
        end
        checks++;
        if (rdata_w !== exp[7:0]) begin
            errors++;
            $display("FAIL %s addr %0h narrow got %0h expected %0h", tag, a, rdata_w, exp[7:0]);
        end
    endtask

    task automatic model_update(logic w, logic [3:0] a, logic [7:0] d, logic [EN-1:0] e);
        if (w && a == 4'h8 && d == 8'h01) begin
            for (int i = 0; i < 4; i++) m_cnt[i] = '0;
            m_run = 1'b1;
        end else if (w && a >= 4 && a < 8) begin
            m_sel[a[1:0]] = d;
            m_run = 1'b0;
        end else if (w && a == 4'h8 && d == 8'h00) begin
            m_run = 1'b0;
        end else if (m_run) begin
            for (int i = 0; i < 4; i++) m_cnt[i] = m_cnt[i] + CW'(evt_hit(m_sel[i], e));
        end
    endtask

    task automatic step(logic w, logic [3:0] a, logic [7:0] d, logic [EN-1:0] e, logic [3:0] ra);
        @(negedge clk);
        cfg_wr = w; cfg_addr = a; cfg_wdata = d; cache_evt = e; cfg_rd_addr = ra;
        #1;
        compare(tag_of(ra), ra, model_read(ra));
        @(posedge clk);
        model_update(w, a, d, e);
    endtask

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        step(1'b1, a, d, '0, 4'h8);
    endtask

    task automatic expect_now(logic [3:0] ra, logic [CW-1:0] exp, string tag);
        @(negedge clk);
        cfg_wr = 1'b0; cache_evt = '0; cfg_rd_addr = ra;
        #1;
        compare(tag, ra, exp);
        @(posedge clk);
        model_update(1'b0, 4'h0, 8'h00, '0);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [EN-1:0] ev;
        logic [EN-1:0] ones;
        void'($urandom(32'h5EED));
        ones = '1;
        for (int i = 0; i < 4; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
        m_run = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        expect_now(4'h0, 0, "R1");
        expect_now(4'h3, 0, "R1");
        expect_now(4'h4, 0, "R1");
        expect_now(4'h7, 0, "R1");
        expect_now(4'h8, 0, "R1");

        // R5 programming while halted
        wr_reg(4'h4, 8'h01);
        wr_reg(4'h5, 8'h17);
        wr_reg(4'h6, 8'h1A);
        wr_reg(4'h7, 8'h00);
        expect_now(4'h8, 0, "R5");
        expect_now(4'h5, 8'h17, "R5");
        expect_now(4'h0, 0, "R5");

        // R3 start, R6/R7 counting
        wr_reg(4'h8, 8'h01);
        for (int k = 0; k < 10; k++) begin
            ev = '0;
            ev[21] = (k % 2 == 0);
            ev[24] = 1'b1;
            step(1'b0, 4'h0, 8'h00, ev, 4'h0);
        end
        expect_now(4'h0, 10, "R6");
        expect_now(4'h1, 5, "R7");
        expect_now(4'h2, 10, "R7");
        expect_now(4'h3, 0, "R6");
        expect_now(4'h8, 1, "R3");

        // R4 stop, R8 halted stability
        wr_reg(4'h8, 8'h00);
        repeat (5) step(1'b0, 4'h0, 8'h00, ones, 4'h1);
        expect_now(4'h0, 15, "R8");
        expect_now(4'h1, 5, "R8");
        expect_now(4'h8, 0, "R4");
        wr_reg(4'h8, 8'h02);
        expect_now(4'h8, 0, "R4");

        // R3 zeroing on start, R4 ignored value while running
        wr_reg(4'h8, 8'h01);
        expect_now(4'h0, 0, "R3");
        expect_now(4'h2, 0, "R3");
        wr_reg(4'h8, 8'h02);
        expect_now(4'h0, 3, "R4");

        // R5 reprogram halts and keeps counts
        wr_reg(4'h7, 8'h1D);
        expect_now(4'h8, 0, "R5");
        expect_now(4'h7, 8'h1D, "R5");
        expect_now(4'h0, 4, "R5");

        // R9 ignored writes
        wr_reg(4'h0, 8'hFF);
        wr_reg(4'hC, 8'h01);
        expect_now(4'h0, 4, "R9");
        expect_now(4'h4, 1, "R9");
        expect_now(4'h8, 0, "R9");

        // R2 unmapped reads
        expect_now(4'hC, 0, "R2");
        expect_now(4'h9, 0, "R2");
        expect_now(4'hF, 0, "R2");

        // R6 codes that never count, R7 eviction code
        wr_reg(4'h5, 8'h2C);
        wr_reg(4'h6, 8'hFF);
        wr_reg(4'h8, 8'h01);
        repeat (5) step(1'b0, 4'h0, 8'h00, ones, 4'h3);
        expect_now(4'h1, 0, "R6");
        expect_now(4'h2, 0, "R6");
        expect_now(4'h3, 5, "R7");

        // R10 wrap of the narrow instance
        wr_reg(4'h8, 8'h01);
        repeat (300) step(1'b0, 4'h0, 8'h00, '0, 4'h0);
        expect_now(4'h0, 300, "R10");

        // seeded random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic       w;
            logic [3:0] a;
            logic [7:0] d;
            logic [3:0] ra;
            int         pick;
            w = ($urandom % 6) == 0;
            a = 4'h0; d = 8'h00;
            if (w) begin
                pick = $urandom % 4;
                if (pick == 0) begin
                    a = 4'h8; d = 8'($urandom % 3);
                end else if (pick == 3) begin
                    a = 4'($urandom); d = 8'($urandom);
                end else begin
                    a = 4'(4 + $urandom % 4);
                    case ($urandom % 8)
                        0: d = 8'h01;
                        1: d = 8'h17;
                        2: d = 8'h18;
                        3: d = 8'h19;
                        4: d = 8'h1A;
                        5: d = 8'h1E;
                        6: d = 8'h00;
                        default: d = 8'($urandom % 64);
                    endcase
                end
            end
            ev = EN'({$urandom, $urandom});
            ra = ($urandom % 2) ? 4'($urandom % 4) : 4'($urandom);
            step(w, a, d, ev, ra);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule